// File: doc/BRIEF.md
# Stream Packet Capture Tap

This block sits beside one direction of a 64-bit AXI4-Stream link that carries PCIe transaction-layer packets and watches it without taking part. Its ports toward the link are inputs only. Every packet on the link travels as one stream packet, so the tap counts a packet each time the final beat is handed over, and it writes every handed-over beat into an internal capture FIFO together with its last-beat flag. The log therefore keeps packet boundaries, and the number of flagged entries matches the packet count.

The same instance serves outgoing or incoming traffic, depending on which set of link signals it is wired to. Capture can be paused with an enable input, while counting continues. A first-word-fall-through read port lets later logic drain the log at its own pace. A beat that arrives while the log is full is lost and is recorded by a sticky overflow flag. The 32-bit packet counter wraps when it overflows.

Top module: `pkt_tap_mon`

## Requirements
- R1: While rst_ni is low and after it is released, pkt_cnt_o is 0, rd_valid_o is 0 and ovf_o is 0.
- R2: pkt_cnt_o increases by exactly one after each rising clock edge where tvalid_i, tready_i and tlast_i are all high. Otherwise it holds its value.
- R3: A beat is written into the log exactly when tvalid_i and tready_i are both high, cap_en_i is high and the log is not full. A beat with only one of tvalid_i and tready_i high is never logged.
- R4: Each log entry holds the 64-bit tdata_i word and the tlast_i bit of its beat. On readout these appear on rd_data_o and rd_last_o, in the order of arrival.
- R5: rd_valid_o is high whenever the log holds at least one entry, and rd_data_o/rd_last_o then show the oldest entry. A rising edge with rd_en_i and rd_valid_o both high removes that entry. rd_en_i while rd_valid_o is low has no effect.
- R6: The log holds DEPTH (512) entries. Whether it is full is judged on the occupancy at the start of the cycle, even if an entry is read in that same cycle. A beat that qualifies under R3 except that the log is full is dropped and sets ovf_o. ovf_o then stays high until reset.
- R7: While cap_en_i is low, no beat is logged and ovf_o is not set, but pkt_cnt_o keeps counting as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_en_i | input | 1 | Capture enable for the log |
| tvalid_i | input | 1 | Observed link valid |
| tready_i | input | 1 | Observed link ready |
| tlast_i | input | 1 | Observed link last-beat flag |
| tdata_i | input | 64 | Observed link data word |
| pkt_cnt_o | output | 32 | Count of completed packets |
| rd_en_i | input | 1 | Pop the oldest log entry |
| rd_valid_o | output | 1 | Log holds at least one entry |
| rd_data_o | output | 64 | Data word of the oldest entry |
| rd_last_o | output | 1 | Last-beat flag of the oldest entry |
| ovf_o | output | 1 | Sticky flag: a beat was lost because the log was full |

## Verification
The hardest state to reach is a full log, with beats still arriving and a read landing in the same cycle, because random traffic with random reads rarely fills 512 entries. The stimulus has a phase that holds the link handshaking on every cycle with reads off until the log overflows. It injects a read together with an incoming beat while the log is full, then drains the log completely and checks the ordering and the flags. Pausing capture with traffic still flowing, and a reset in the middle of the run, cover the enable and the sticky flag.

// File: rtl/pkt_tap_pkg.sv
package pkt_tap_pkg;
  localparam int unsigned DATA_W = 64;

  typedef struct packed {
    logic              last;
    logic [DATA_W-1:0] data;
  } cap_entry_t;

  localparam int unsigned ENTRY_W = $bits(cap_entry_t);
endpackage

// File: rtl/pkt_tap_counter.sv
module pkt_tap_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;  // wraps
  end

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_o == $past(cnt_o) + 1'b1);
  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/pkt_tap_fifo.sv
module pkt_tap_fifo #(
  parameter int unsigned WIDTH = 65,
  parameter int unsigned DEPTH = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic             rd_valid_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, push, pop;

  assign full       = (cnt_q == FULL_CNT);
  assign rd_valid_o = (cnt_q != '0);
  assign push       = wr_req_i && !full;   // full judged on start-of-cycle occupancy
  assign pop        = rd_en_i && rd_valid_o;
  assign rd_data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (wr_req_i && full) ovf_o <= 1'b1;
    end
  end

  assert_occupancy_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  assert_no_req_no_growth_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_i |=> cnt_q <= $past(cnt_q));
  assert_empty_stays_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_valid_o && !wr_req_i) |=> !rd_valid_o);
endmodule

// File: rtl/pkt_tap_mon.sv
module pkt_tap_mon
  import pkt_tap_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned DEPTH = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic              tvalid_i,
  input  logic              tready_i,
  input  logic              tlast_i,
  input  logic [DATA_W-1:0] tdata_i,
  output logic [CNT_W-1:0]  pkt_cnt_o,
  input  logic              rd_en_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic              ovf_o
);
  logic       beat_acc, last_acc;
  cap_entry_t wr_entry, rd_entry;

  assign beat_acc = tvalid_i && tready_i;
  assign last_acc = beat_acc && tlast_i;
  assign wr_entry = '{last: tlast_i, data: tdata_i};

  pkt_tap_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (last_acc),
    .cnt_o  (pkt_cnt_o)
  );

  pkt_tap_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_req_i   (beat_acc && cap_en_i),
    .wr_data_i  (wr_entry),
    .rd_en_i    (rd_en_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_entry),
    .ovf_o      (ovf_o)
  );

  assign rd_data_o = rd_entry.data;
  assign rd_last_o = rd_entry.last;

  assert_paused_no_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i && !ovf_o) |=> !ovf_o);
endmodule

// File: tb/test_pkt_tap_mon.sv
module test_pkt_tap_mon;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 512;
  localparam int WATCHDOG   = 20000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cap_en_i = 1'b0, tvalid_i = 1'b0, tready_i = 1'b0, tlast_i = 1'b0;
  logic [63:0] tdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] pkt_cnt_o;
  logic        rd_valid_o, rd_last_o, ovf_o;
  logic [63:0] rd_data_o;

  pkt_tap_mon i_pkt_tap_mon (
    .clk_i, .rst_ni, .cap_en_i, .tvalid_i, .tready_i, .tlast_i, .tdata_i,
    .pkt_cnt_o, .rd_en_i, .rd_valid_o, .rd_data_o, .rd_last_o, .ovf_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int          n_run = 0, n_fail = 0;
  logic [64:0] m_q[$];
  logic [31:0] m_cnt = '0;
  bit          m_ovf = 1'b0;
  bit          done  = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare outputs with the model state (called at negedge)
  task automatic compare();
    chk(pkt_cnt_o == m_cnt, "R2 pkt_cnt", 65'(pkt_cnt_o), 65'(m_cnt));
    chk(ovf_o == m_ovf, "R6 ovf", 65'(ovf_o), 65'(m_ovf));
    chk(rd_valid_o == (m_q.size() != 0), "R5 rd_valid", 65'(rd_valid_o), 65'(m_q.size() != 0));
    if (m_q.size() != 0)
      chk({rd_last_o, rd_data_o} == m_q[0], "R4 rd_entry", {rd_last_o, rd_data_o}, m_q[0]);
  endtask

  // drive one cycle of inputs and advance the model to the post-edge state
  task automatic step(input bit en, input bit v, input bit r, input bit l, input bit rd);
    bit acc, full, rdv;
    compare();
    cap_en_i = en; tvalid_i = v; tready_i = r; tlast_i = l; rd_en_i = rd;
    tdata_i  = {$urandom(), $urandom()};
    acc  = v && r;
    full = (m_q.size() == DEPTH);
    rdv  = (m_q.size() != 0);
    if (acc && l) m_cnt++;
    if (rd && rdv) void'(m_q.pop_front());
    if (acc && en) begin
      if (full) m_ovf = 1'b1;
      else m_q.push_back({l, tdata_i});
    end
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    chk(pkt_cnt_o == 0 && !rd_valid_o && !ovf_o, "R1 reset", {ovf_o, rd_valid_o, 31'd0, pkt_cnt_o[31:0]}, 65'd0);
    m_q.delete(); m_cnt = '0; m_ovf = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    @(negedge clk_i);
    do_reset();
    @(negedge clk_i);
    // R1: idle after release
    chk(pkt_cnt_o == 0 && !rd_valid_o && !ovf_o, "R1 post-reset", 65'(pkt_cnt_o), 65'd0);
    // R2/R3/R4/R5: random traffic with random reads, some single-sided handshakes
    for (int i = 0; i < 600; i++)
      step(1'b1, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3) == 0, $urandom_range(0, 1));
    // R5: reads while empty are ignored
    for (int i = 0; i < 600; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    // R6: fill to overflow, no reads
    for (int i = 0; i < DEPTH + 20; i++) step(1'b1, 1'b1, 1'b1, (i % 5) == 4, 1'b0);
    // R6: full with a read and a beat in the same cycle -> beat dropped
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7: paused capture with traffic, counter keeps running
    for (int i = 0; i < 100; i++) step(1'b0, 1'b1, $urandom_range(0, 1), $urandom_range(0, 1), 1'b0);
    // drain completely, checking order and flags
    for (int i = 0; i < DEPTH + 10; i++) step(1'b0, 1'b1, 1'b1, $urandom_range(0, 1), 1'b1);
    // R7: paused from empty, no logging
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, 1'b1, 1'b1, $urandom_range(0, 1));
    // R6: ovf sticky across activity, then cleared by reset (R1)
    for (int i = 0; i < 300; i++)
      step(1'b1, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    do_reset();
    @(negedge clk_i);
    for (int i = 0; i < 300; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), 1'b1, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
    compare();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule